// File: doc/BRIEF.md
# CSR Access Check And Read-Modify-Write

This block carries out the three control-register instruction forms against an attached register file port. The forms are swap, set-bits and clear-bits. Each request first passes an access check that uses only the 12-bit register address, the current privilege level and the counter-enable masks. A legal request reads the old value in the cycle it is accepted. In the next cycle the block signals done, returns the old value and, where the form calls for it, writes the merged value back.

Privilege and writability are decoded from the address itself. Bits 9:8 hold the lowest privilege allowed to touch the register. Bits 11:10 equal to 2'b11 mark it as read-only.

The user counter window is 0xC00 to 0xC1F. Access to it is gated by a counter-enable bit, selected by the low five address bits. Entries at index 3 and above are answered with zero inside the block, without touching the register file. An address the register file does not know is flagged by the file during the read and is reported as illegal. An illegal request never writes and returns zero.

Top module: `csr_rmw_unit`

## Requirements
- R1: A request whose privilege level (0 user, 1 supervisor, 3 machine) is numerically below address bits 9:8 is illegal; an equal or higher level passes this check.
- R2: When address bits 11:10 are 2'b11, any request with write intent is illegal.
- R3: Swap (op 2'b01) always has write intent; it returns the old value and writes the source operand.
- R4: Set (op 2'b10) writes old OR source; clear (op 2'b11) writes old AND NOT source.
- R5: For set and clear with src_nz low, no write is issued, the read-only check of R2 does not apply, and the old value is returned.
- R6: An accepted request raises rf_rd_en in its own cycle. done, result, illegal and any write follow exactly one cycle later. req_valid is ignored in the done cycle.
- R7: For addresses 0xC00 to 0xC1F, the enable bit indexed by address bits 4:0 is taken from cnt_en_user in user mode and from cnt_en_super in supervisor mode; machine mode is always enabled. A clear bit makes the request illegal. A permitted read at index 3 or above returns zero with no register file read.
- R8: An illegal request issues no write and returns result zero. A request found illegal by the access check also issues no read. When rf_rd_unknown is high during the read, the request is illegal.
- R9: Op code 2'b00 is illegal.
- R10: During reset, done, rf_rd_en and rf_wr_en are low and result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 01 swap, 10 set, 11 clear, 00 illegal |
| req_addr | input | 12 | Register address |
| req_src | input | XLEN | Source operand |
| req_src_nz | input | 1 | Source register field is non-zero |
| req_priv | input | 2 | Current privilege level |
| cnt_en_user | input | CNT_N | Counter enables applied in user mode |
| cnt_en_super | input | CNT_N | Counter enables applied in supervisor mode |
| rf_rd_en | output | 1 | Register file read request |
| rf_addr | output | 12 | Register file address for read or write |
| rf_rd_data | input | XLEN | Register file read data (same cycle) |
| rf_rd_unknown | input | 1 | Register file reports the read address as unknown |
| rf_wr_en | output | 1 | Register file write request |
| rf_wr_data | output | XLEN | Register file write data |
| done | output | 1 | Result valid pulse |
| illegal | output | 1 | Request was illegal (valid with done) |
| result | output | XLEN | Old register value, zero when illegal |

## Verification
The whole request state lives in one registered record. A fault in that record shows at the ports exactly one cycle after acceptance:
- a lost busy flag drops the done pulse;
- a stuck busy flag blocks the next request;
- a wrong captured old value or source shows directly on result or rf_wr_data;
- a wrong write-needed flag shows as a missing write or a spurious one in the done cycle.

Access-check faults show even earlier, in the accept cycle, as a read issued or withheld on rf_rd_en.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_SWAP  = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    localparam logic [1:0] PRIV_USER  = 2'd0;
    localparam logic [1:0] PRIV_SUPER = 2'd1;
    localparam logic [1:0] PRIV_MACH  = 2'd3;

    localparam logic [1:0] RO_MARK = 2'b11;

endpackage

// File: rtl/csr_rmw_access.sv
module csr_rmw_access
    import csr_rmw_pkg::*;
#(
    parameter int          CNT_N         = 32,
    parameter logic [11:0] CNT_BASE      = 12'hC00,
    parameter int          CNT_ZERO_FROM = 3
) (
    input  logic [1:0]       op,
    input  logic [11:0]      addr,
    input  logic             src_nz,
    input  logic [1:0]       priv,
    input  logic [CNT_N-1:0] en_user,
    input  logic [CNT_N-1:0] en_super,
    output logic             acc_illegal,
    output logic             acc_wr_intent,
    output logic             acc_local_zero
);
    localparam int               IDX_W = $clog2(CNT_N);
    localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(CNT_ZERO_FROM);

    logic             bad_op;
    logic             priv_low;
    logic             ro_write;
    logic             in_cnt;
    logic             cnt_ok;
    logic [IDX_W-1:0] idx;
    logic [CNT_N-1:0] en_vec;

    // R9 reserved op code, R3/R5 write intent
    assign bad_op        = (op == OP_NONE);
    assign acc_wr_intent = (op == OP_SWAP) || (!bad_op && src_nz);

    // R1 privilege field, R2 read-only field
    assign priv_low = (priv < addr[9:8]);
    assign ro_write = (addr[11:10] == RO_MARK) && acc_wr_intent;

    // R7 counter window and enable selection
    assign idx    = addr[IDX_W-1:0];
    assign in_cnt = (addr[11:IDX_W] == CNT_BASE[11:IDX_W]);

    always_comb begin
        case (priv)
            PRIV_USER:  en_vec = en_user;
            PRIV_SUPER: en_vec = en_super;
            default:    en_vec = '1;
        endcase
    end

    assign cnt_ok         = en_vec[idx];
    assign acc_illegal    = bad_op || priv_low || ro_write || (in_cnt && !cnt_ok);
    assign acc_local_zero = in_cnt && cnt_ok && (idx >= ZERO_IDX);

endmodule

// File: rtl/csr_rmw_merge.sv
module csr_rmw_merge
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_e         op,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src,
    output logic [XLEN-1:0] wdata
);
    // R3/R4 per-bit merge of old value and source
    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        assign wdata[b] = (op == OP_SWAP)  ? src[b] :
                          (op == OP_SET)   ? (old_val[b] | src[b]) :
                          (op == OP_CLEAR) ? (old_val[b] & ~src[b]) :
                                             old_val[b];
    end

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int          XLEN          = 32,
    parameter int          CNT_N         = 32,
    parameter logic [11:0] CNT_BASE      = 12'hC00,
    parameter int          CNT_ZERO_FROM = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [11:0]      req_addr,
    input  logic [XLEN-1:0]  req_src,
    input  logic             req_src_nz,
    input  logic [1:0]       req_priv,
    input  logic [CNT_N-1:0] cnt_en_user,
    input  logic [CNT_N-1:0] cnt_en_super,
    output logic             rf_rd_en,
    output logic [11:0]      rf_addr,
    input  logic [XLEN-1:0]  rf_rd_data,
    input  logic             rf_rd_unknown,
    output logic             rf_wr_en,
    output logic [XLEN-1:0]  rf_wr_data,
    output logic             done,
    output logic             illegal,
    output logic [XLEN-1:0]  result
);
    typedef struct packed {
        logic            busy;
        logic            illegal;
        logic            wr_need;
        csr_op_e         op;
        logic [11:0]     addr;
        logic [XLEN-1:0] src;
        logic [XLEN-1:0] old;
    } rmw_state_t;

    rmw_state_t st_d, st_q;

    logic accept;
    logic acc_illegal;
    logic acc_wr_intent;
    logic acc_local_zero;
    logic bad_now;

    csr_rmw_access #(
        .CNT_N        (CNT_N),
        .CNT_BASE     (CNT_BASE),
        .CNT_ZERO_FROM(CNT_ZERO_FROM)
    ) u_access (
        .op            (req_op),
        .addr          (req_addr),
        .src_nz        (req_src_nz),
        .priv          (req_priv),
        .en_user       (cnt_en_user),
        .en_super      (cnt_en_super),
        .acc_illegal   (acc_illegal),
        .acc_wr_intent (acc_wr_intent),
        .acc_local_zero(acc_local_zero)
    );

    csr_rmw_merge #(
        .XLEN(XLEN)
    ) u_merge (
        .op     (st_q.op),
        .old_val(st_q.old),
        .src    (st_q.src),
        .wdata  (rf_wr_data)
    );

    // R6 one request in flight; the done cycle ignores req_valid
    assign accept   = req_valid && !st_q.busy;
    // R8 no read for a request the access check rejects; R7 local zero
    assign rf_rd_en = accept && !acc_illegal && !acc_local_zero;
    assign bad_now  = acc_illegal || (rf_rd_en && rf_rd_unknown);

    always_comb begin
        st_d         = st_q;
        st_d.busy    = 1'b0;
        st_d.illegal = 1'b0;
        st_d.wr_need = 1'b0;
        if (accept) begin
            st_d.busy    = 1'b1;
            st_d.illegal = bad_now;
            st_d.wr_need = acc_wr_intent && !bad_now;
            st_d.old     = (bad_now || acc_local_zero) ? '0 : rf_rd_data;
            st_d.op      = csr_op_e'(req_op);
            st_d.addr    = req_addr;
            st_d.src     = req_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rf_addr  = st_q.busy ? st_q.addr : req_addr;
    assign rf_wr_en = st_q.busy && st_q.wr_need;
    assign done     = st_q.busy;
    assign illegal  = st_q.busy && st_q.illegal;
    assign result   = st_q.busy ? st_q.old : '0;

endmodule

// File: rtl/csr_rmw_unit_chk.sv
module csr_rmw_unit_chk
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_op,
    input logic [11:0]     req_addr,
    input logic [XLEN-1:0] req_src,
    input logic            req_src_nz,
    input logic [1:0]      req_priv,
    input logic            rf_rd_en,
    input logic [XLEN-1:0] rf_rd_data,
    input logic            rf_wr_en,
    input logic [XLEN-1:0] rf_wr_data,
    input logic            done,
    input logic            illegal,
    input logic [XLEN-1:0] result
);
    logic acc;
    assign acc = req_valid && !done;

    AST_ACCEPT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> done); // R6
    AST_RD_NOT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |-> !done); // R6
    AST_WR_ONLY_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> done); // R6
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!rf_wr_en && result == '0)); // R8
    AST_PRIV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_priv < req_addr[9:8]) |=> illegal); // R1
    AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr[11:10] == 2'b11 && (req_op == OP_SWAP || (req_op != OP_NONE && req_src_nz)))
        |=> (illegal && !rf_wr_en)); // R2
    AST_SWAP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == OP_SWAP) |=> (illegal || (rf_wr_en && rf_wr_data == $past(req_src)))); // R3
    AST_SET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rf_rd_en && req_op == OP_SET) |=>
        (!rf_wr_en || rf_wr_data == ($past(rf_rd_data) | $past(req_src)))); // R4
    AST_CLEAR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rf_rd_en && req_op == OP_CLEAR) |=>
        (!rf_wr_en || rf_wr_data == ($past(rf_rd_data) & ~$past(req_src)))); // R4
    AST_SKIP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (req_op == OP_SET || req_op == OP_CLEAR) && !req_src_nz) |=> !rf_wr_en); // R5
    AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == OP_NONE) |=> illegal); // R9

endmodule

bind csr_rmw_unit csr_rmw_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/csr_rmw_unit_test.sv
module csr_rmw_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] src;
        logic        nz;
        logic [1:0]  priv;
        logic [31:0] rd;
        logic        unk;
        logic        e_rd;
        logic        e_ill;
        logic [31:0] e_res;
        logic        e_wr;
        logic [31:0] e_wd;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'b01, 12'h340, 32'hA5A50000, 1'b1, 2'd3, 32'h12345678, 1'b0, 1'b1, 1'b0, 32'h12345678, 1'b1, 32'hA5A50000}, // R3 swap
        '{2'b10, 12'h340, 32'h000000F0, 1'b1, 2'd3, 32'h12345678, 1'b0, 1'b1, 1'b0, 32'h12345678, 1'b1, 32'h123456F8}, // R4 set
        '{2'b11, 12'h340, 32'h00000078, 1'b1, 2'd3, 32'h12345678, 1'b0, 1'b1, 1'b0, 32'h12345678, 1'b1, 32'h12345600}, // R4 clear
        '{2'b10, 12'h340, 32'h0000FFFF, 1'b0, 2'd3, 32'h12345678, 1'b0, 1'b1, 1'b0, 32'h12345678, 1'b0, 32'h0},        // R5 no write
        '{2'b01, 12'h340, 32'h00000001, 1'b1, 2'd1, 32'h12345678, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 32'h0},        // R1 low priv
        '{2'b01, 12'h100, 32'h00000005, 1'b1, 2'd1, 32'hDEADBEEF, 1'b0, 1'b1, 1'b0, 32'hDEADBEEF, 1'b1, 32'h00000005}, // R1 equal priv
        '{2'b01, 12'hF14, 32'h00000001, 1'b1, 2'd3, 32'h00000007, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 32'h0},        // R2 swap ro
        '{2'b10, 12'hF14, 32'h00000001, 1'b0, 2'd3, 32'h00000007, 1'b0, 1'b1, 1'b0, 32'h00000007, 1'b0, 32'h0},        // R5 ro read
        '{2'b10, 12'hF11, 32'h00000001, 1'b1, 2'd3, 32'h00000007, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 32'h0},        // R2 set ro
        '{2'b11, 12'hC03, 32'h0,        1'b0, 2'd0, 32'h00007777, 1'b0, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0},        // R7 user zero
        '{2'b10, 12'hC04, 32'h0,        1'b0, 2'd0, 32'h00007777, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 32'h0},        // R7 user denied
        '{2'b10, 12'hC04, 32'h0,        1'b0, 2'd1, 32'h00007777, 1'b0, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0},        // R7 super zero
        '{2'b10, 12'hC05, 32'h0,        1'b0, 2'd3, 32'h00007777, 1'b0, 1'b0, 1'b0, 32'h0,        1'b0, 32'h0},        // R7 machine
        '{2'b10, 12'hC00, 32'h0,        1'b0, 2'd0, 32'hCAFE0001, 1'b0, 1'b1, 1'b0, 32'hCAFE0001, 1'b0, 32'h0},        // R7 low idx read
        '{2'b10, 12'hC01, 32'h0,        1'b0, 2'd0, 32'hCAFE0001, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 32'h0},        // R7 low idx denied
        '{2'b00, 12'h340, 32'h1,        1'b1, 2'd3, 32'h12345678, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 32'h0},        // R9 bad op
        '{2'b01, 12'h7C0, 32'h1,        1'b1, 2'd3, 32'h12345678, 1'b1, 1'b1, 1'b1, 32'h0,        1'b0, 32'h0},        // R8 unknown
        '{2'b11, 12'hC00, 32'h1,        1'b1, 2'd3, 32'hCAFE0001, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 32'h0}         // R2 counter write
    };
    localparam string TAGS [NV] = '{"R3", "R4", "R4", "R5", "R1", "R1", "R2", "R5", "R2",
                                    "R7", "R7", "R7", "R7", "R7", "R7", "R9", "R8", "R2"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_src = '0;
    logic        req_src_nz = 1'b0;
    logic [1:0]  req_priv = '0;
    logic [31:0] cnt_en_user = 32'h0000_0009;
    logic [31:0] cnt_en_super = 32'h0000_0010;
    logic        rf_rd_en;
    logic [11:0] rf_addr;
    logic [31:0] rf_rd_data = '0;
    logic        rf_rd_unknown = 1'b0;
    logic        rf_wr_en;
    logic [31:0] rf_wr_data;
    logic        done;
    logic        illegal;
    logic [31:0] result;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    csr_rmw_unit uut (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 idle during reset
        chk("R10", "done", 32'(done), 32'h0);
        chk("R10", "rd_en", 32'(rf_rd_en), 32'h0);
        chk("R10", "wr_en", 32'(rf_wr_en), 32'h0);
        chk("R10", "result", result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid     = 1'b1;
            req_op        = VECS[i].op;
            req_addr      = VECS[i].addr;
            req_src       = VECS[i].src;
            req_src_nz    = VECS[i].nz;
            req_priv      = VECS[i].priv;
            rf_rd_data    = VECS[i].rd;
            rf_rd_unknown = VECS[i].unk;
            #1;
            chk(TAGS[i], "rd_en", 32'(rf_rd_en), 32'(VECS[i].e_rd));
            chk("R6", "done in accept cycle", 32'(done), 32'h0);
            @(negedge clk);
            req_valid     = 1'b0;
            rf_rd_unknown = 1'b0;
            chk("R6", "done", 32'(done), 32'h1);
            chk(TAGS[i], "illegal", 32'(illegal), 32'(VECS[i].e_ill));
            chk(TAGS[i], "result", result, VECS[i].e_res);
            chk(TAGS[i], "wr_en", 32'(rf_wr_en), 32'(VECS[i].e_wr));
            if (VECS[i].e_wr) begin
                chk(TAGS[i], "wr_data", rf_wr_data, VECS[i].e_wd);
                chk(TAGS[i], "wr_addr", 32'(rf_addr), 32'(VECS[i].addr));
            end
        end

        // R6 valid held into the done cycle is ignored
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = 2'b01;
        req_addr   = 12'h340;
        req_src    = 32'h0000_00AA;
        req_src_nz = 1'b1;
        req_priv   = 2'd3;
        rf_rd_data = 32'h0000_0011;
        @(negedge clk);
        #1;
        chk("R6", "no read in done cycle", 32'(rf_rd_en), 32'h0);
        chk("R6", "swap result", result, 32'h0000_0011);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R6", "no done after ignored valid", 32'(done), 32'h0);
        chk("R6", "no write after ignored valid", 32'(rf_wr_en), 32'h0);

        // R10 reset mid-request clears the pending result
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n     = 1'b0;
        #1;
        chk("R10", "done under reset", 32'(done), 32'h0);
        chk("R10", "wr_en under reset", 32'(rf_wr_en), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule